// File: doc/BRIEF.md
# Multi-Channel Burst DMA Scheduler

This block chooses which of several DMA channels the data mover serves next, one burst at a time. Each channel is loaded with a request-line select, a burst-size code, a byte count and an interrupt enable. Loading a non-zero count makes the channel active. A channel can take part in arbitration only when it is active and its selected request line is asserted. Request lines are either on-chip peripheral levels or external pins. An external pin is synchronised, and each rising edge latches one pending request.

The scheduler arbitrates only while no burst is outstanding. It presents one command, made of a channel number and a byte count, to the data mover over a valid/ready handshake. It then waits for a one-cycle done pulse before it arbitrates again. Request lines have no effect while a burst is in flight, so a channel is never cut off in mid-burst.

Channels form priority groups of equal size, and group 0 ranks highest. Inside a group, a rotating pointer shares service fairly. Each finished burst is subtracted from the channel's count. The last burst is trimmed to the bytes that remain. When the count reaches zero, the channel drops out and raises a sticky done flag, and the interrupt output reports that flag if the channel's interrupt enable is set.

Top module: `dma_burst_sched`

## Requirements
- R1: After reset, cmd_valid, irq, every bit of ch_done and every bit of ch_active are 0.
- R2: A channel is eligible only when it is active and its selected line is asserted. Select values 0..N_PREQ-1 pick preq[sel]. Values N_PREQ..N_PREQ+N_XREQ-1 pick the pending flag of xreq[sel-N_PREQ]. A load with count 0 leaves the channel inactive.
- R3: Channel c belongs to group c / (N_CH/N_GRP). When several groups hold eligible channels, the group with the lowest index is served.
- R4: Within a group, the search for an eligible channel starts one place after the channel last granted in that group and wraps around. After reset the search starts at the group's first channel.
- R5: Burst code 0 means 8 bytes, 1 means 16 and 2 or 3 means 32. Each command carries the smaller of the burst size and the remaining count.
- R6: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_ch and cmd_bytes hold their values.
- R7: Between an accepted command and the following mv_done, cmd_valid stays low. Request lines have no effect in that interval.
- R8: An external line raises one pending request per 0-to-1 edge, and issuing a burst for that line clears it. A level held high does not produce a further burst.
- R9: When a burst brings a channel's count to zero, that channel's ch_active bit clears and its ch_done bit sets. irq is the OR of the ch_done bits whose interrupt enable is set.
- R10: A load clears the channel's done flag. A load is ignored for the channel whose burst is outstanding, or whose burst is being picked in that cycle.
- R11: A higher-priority request that arrives during a burst does not end that burst. That channel is served by the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load a channel's settings |
| cfg_ch | input | 4 | Channel to load |
| cfg_sel | input | 6 | Request-line select |
| cfg_bsize | input | 2 | Burst-size code |
| cfg_count | input | 16 | Byte count of the transfer |
| cfg_ien | input | 1 | Interrupt enable for the channel |
| preq | input | 38 | On-chip peripheral request levels |
| xreq | input | 2 | External request pins, edge detected |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_ch | output | 4 | Channel of the command |
| cmd_bytes | output | 6 | Byte count of the burst |
| mv_done | input | 1 | One-cycle pulse when the burst has moved |
| irq | output | 1 | Active-high interrupt |
| ch_done | output | 16 | Sticky per-channel done flags |
| ch_active | output | 16 | Per-channel active flags |

## Verification
The bench builds the block with its default parameters: 16 channels in 4 groups of 4, 38 internal lines, 2 external lines and a 16-bit count. With these values, group priority, rotation inside one group and both external lines can be exercised with a handful of channels. Counts up to 100 bytes reach the trimmed last burst for every size code. A table of size codes and counts checks the sequence of burst lengths. Directed cases then cover priority across groups, rotation, holding a command stalled, a request that arrives mid-burst, external edges against held levels, and the interrupt-enable masking.

// File: rtl/dsch_pkg.sv
// Shared types and helpers for the burst DMA scheduler.
// Assumes burst sizes are powers of two no larger than 32 bytes.
package dsch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_BUSY  = 2'd2
    } sched_st_t;

    localparam int BYTES_W = 6;

    // Map the burst-size code to bytes; codes above 2 saturate at 32.
    function automatic logic [BYTES_W-1:0] burst_len(input logic [1:0] code);
        case (code)
            2'd0:    burst_len = 6'd8;
            2'd1:    burst_len = 6'd16;
            default: burst_len = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/dsch_ext_req.sv
// External request conditioner: synchronises one asynchronous pin,
// detects a 0-to-1 transition and holds it as a pending flag until cleared.
// Assumes the pin stays high long enough to pass the synchroniser.
module dsch_ext_req #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;

    // Shift the pin through the synchroniser chain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

    // Pending flag: a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= rise | (pend & ~clr);
    end
endmodule

// File: rtl/dsch_rr_arb.sv
// Round-robin picker for one priority group. It searches from the pointer
// upwards with wrap-around, and moves the pointer past the pick when adv is high.
module dsch_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;

    // Find the first request at or after the pointer.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int k;
            k = (int'(ptr_q) + off) % N;
            if (req[k]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(k);
            end
        end
    end

    // Advance the pointer to one past the granted index.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (adv && gnt_any) ptr_q <= IW'((int'(gnt_idx) + 1) % N);
    end
endmodule

// File: rtl/dma_burst_sched.sv
// Burst DMA scheduler top. It holds the per-channel state, maps request lines
// to channels, arbitrates by group priority and then round robin, and runs the
// issue/wait handshake with the data mover. It assumes one outstanding burst
// and a single-cycle mv_done that comes only after a command was accepted.
module dma_burst_sched
    import dsch_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int N_GRP  = 4,
    parameter int N_PREQ = 38,
    parameter int N_XREQ = 2,
    parameter int CNT_W  = 16,
    localparam int CW    = $clog2(N_CH),
    localparam int NL    = N_PREQ + N_XREQ,
    localparam int SW    = $clog2(NL),
    localparam int GSZ   = N_CH / N_GRP,
    localparam int GIW   = (GSZ > 1) ? $clog2(GSZ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CW-1:0]      cfg_ch,
    input  logic [SW-1:0]      cfg_sel,
    input  logic [1:0]         cfg_bsize,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic               cfg_ien,
    input  logic [N_PREQ-1:0]  preq,
    input  logic [N_XREQ-1:0]  xreq,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CW-1:0]      cmd_ch,
    output logic [BYTES_W-1:0] cmd_bytes,
    input  logic               mv_done,
    output logic               irq,
    output logic [N_CH-1:0]    ch_done,
    output logic [N_CH-1:0]    ch_active
);
    sched_st_t           st_q;
    logic [CW-1:0]       cur_ch_q;
    logic [BYTES_W-1:0]  cur_bytes_q;

    logic [SW-1:0]       ch_sel   [N_CH];
    logic [1:0]          ch_bsz   [N_CH];
    logic [CNT_W-1:0]    ch_cnt   [N_CH];
    logic [N_CH-1:0]     ch_ien;
    logic [N_CH-1:0]     act_q;
    logic [N_CH-1:0]     done_q;

    logic [N_XREQ-1:0]   xpend;
    logic [N_XREQ-1:0]   xclr;
    logic [NL-1:0]       line_vec;
    logic [N_CH-1:0]     ch_req;
    logic [N_CH-1:0]     elig;

    logic [N_GRP-1:0]    grp_any;
    logic [GIW-1:0]      grp_idx  [N_GRP];
    logic [N_GRP-1:0]    grp_adv;

    logic                win_any;
    logic [CW-1:0]       win_ch;
    logic [BYTES_W-1:0]  win_bytes;
    logic                pick;
    logic                fire;
    logic                finish;
    logic                cfg_lock;

    assign pick   = (st_q == ST_IDLE) && win_any;
    assign fire   = (st_q == ST_ISSUE) && cmd_ready;
    assign finish = (st_q == ST_BUSY) && mv_done;

    // External pins: synchronise, detect edges, hold pending until issued.
    generate
        for (genvar k = 0; k < N_XREQ; k++) begin : g_xreq
            assign xclr[k] = fire && (ch_sel[cur_ch_q] == SW'(N_PREQ + k));
            dsch_ext_req #(.SYNC_STAGES(2)) u_xr (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (xreq[k]),
                .clr  (xclr[k]),
                .pend (xpend[k])
            );
        end
    endgenerate

    assign line_vec = {xpend, preq};

    // Route each channel's selected request line and qualify it with active.
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            ch_req[i] = (int'(ch_sel[i]) < NL) ? line_vec[ch_sel[i]] : 1'b0;
        end
        elig = act_q & ch_req;
    end

    // One round-robin picker per priority group.
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            assign grp_adv[g] = pick && (win_ch / CW'(GSZ) == CW'(g));
            dsch_rr_arb #(.N(GSZ)) u_arb (
                .clk    (clk),
                .rst_n  (rst_n),
                .req    (elig[g*GSZ +: GSZ]),
                .adv    (grp_adv[g]),
                .gnt_any(grp_any[g]),
                .gnt_idx(grp_idx[g])
            );
        end
    endgenerate

    // Fixed priority across groups: the lowest group index wins.
    always_comb begin
        win_any = 1'b0;
        win_ch  = '0;
        for (int g = N_GRP - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                win_any = 1'b1;
                win_ch  = CW'(g * GSZ) + CW'(grp_idx[g]);
            end
        end
    end

    // Trim the winner's burst to what is left of its count.
    always_comb begin
        logic [CNT_W-1:0] full;
        full = CNT_W'(burst_len(ch_bsz[win_ch]));
        if (ch_cnt[win_ch] < full) win_bytes = BYTES_W'(ch_cnt[win_ch]);
        else                       win_bytes = BYTES_W'(full);
    end

    // Scheduler state: pick, offer the command, wait for done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cur_ch_q    <= '0;
            cur_bytes_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (win_any) begin
                    cur_ch_q    <= win_ch;
                    cur_bytes_q <= win_bytes;
                    st_q        <= ST_ISSUE;
                end
                ST_ISSUE: if (cmd_ready) st_q <= ST_BUSY;
                ST_BUSY:  if (mv_done)   st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Loads aimed at the channel being picked or served are ignored.
    assign cfg_lock = ((st_q != ST_IDLE) && (cfg_ch == cur_ch_q)) ||
                      (pick && (cfg_ch == win_ch));

    // Per-channel settings, remaining count and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) begin
                ch_sel[i] <= '0;
                ch_bsz[i] <= '0;
                ch_cnt[i] <= '0;
            end
            ch_ien <= '0;
            act_q  <= '0;
            done_q <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (cfg_we && !cfg_lock && (cfg_ch == CW'(i))) begin
                    ch_sel[i] <= cfg_sel;
                    ch_bsz[i] <= cfg_bsize;
                    ch_cnt[i] <= cfg_count;
                    ch_ien[i] <= cfg_ien;
                    act_q[i]  <= (cfg_count != '0);
                    done_q[i] <= 1'b0;
                end else if (finish && (cur_ch_q == CW'(i))) begin
                    ch_cnt[i] <= ch_cnt[i] - CNT_W'(cur_bytes_q);
                    if (ch_cnt[i] == CNT_W'(cur_bytes_q)) begin
                        act_q[i]  <= 1'b0;
                        done_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    assign cmd_valid = (st_q == ST_ISSUE);
    assign cmd_ch    = cur_ch_q;
    assign cmd_bytes = cur_bytes_q;
    assign irq       = |(done_q & ch_ien);
    assign ch_done   = done_q;
    assign ch_active = act_q;
endmodule

// File: rtl/dsch_checker.sv
// Protocol checker for the burst scheduler, attached by bind. It tracks the
// outstanding burst from the handshake ports only.
module dsch_checker #(
    parameter int N_CH = 16,
    parameter int CW   = 4,
    parameter int BW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [CW-1:0]   cmd_ch,
    input logic [BW-1:0]   cmd_bytes,
    input logic            mv_done,
    input logic            irq,
    input logic [N_CH-1:0] ch_done,
    input logic [N_CH-1:0] ch_active
);
    logic out_q;

    // Track whether an accepted burst still awaits its done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                      out_q <= 1'b0;
        else if (cmd_valid && cmd_ready) out_q <= 1'b1;
        else if (mv_done)                out_q <= 1'b0;
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_ch) && $stable(cmd_bytes))); // R6
    AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_bytes != '0 && cmd_bytes <= BW'(32))); // R5
    AST_SINGLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !cmd_valid); // R7
    AST_DONE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done & ch_active) == '0); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ch_done != '0)); // R9
endmodule

bind dma_burst_sched dsch_checker #(
    .N_CH(N_CH),
    .CW  (CW),
    .BW  (dsch_pkg::BYTES_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_ch   (cmd_ch),
    .cmd_bytes(cmd_bytes),
    .mv_done  (mv_done),
    .irq      (irq),
    .ch_done  (ch_done),
    .ch_active(ch_active)
);

// File: tb/dma_burst_sched_tb_top.sv
// Self-checking bench: a vector table of burst sequences, then directed cases.
module dma_burst_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ch = '0;
    logic [5:0]  cfg_sel = '0;
    logic [1:0]  cfg_bsize = '0;
    logic [15:0] cfg_count = '0;
    logic        cfg_ien = 1'b0;
    logic [37:0] preq = '0;
    logic [1:0]  xreq = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [3:0]  cmd_ch;
    logic [5:0]  cmd_bytes;
    logic        mv_done = 1'b0;
    logic        irq;
    logic [15:0] ch_done;
    logic [15:0] ch_active;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_burst_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_bsize(cfg_bsize), .cfg_count(cfg_count),
        .cfg_ien(cfg_ien), .preq(preq), .xreq(xreq), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_ch(cmd_ch), .cmd_bytes(cmd_bytes),
        .mv_done(mv_done), .irq(irq), .ch_done(ch_done), .ch_active(ch_active)
    );

    typedef struct packed {
        logic [1:0]  bsz;
        logic [15:0] cnt;
        logic [5:0]  first;
        logic [3:0]  nb;
        logic [5:0]  last;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 16'd8,   6'd8,  4'd1, 6'd8},
        '{2'd0, 16'd20,  6'd8,  4'd3, 6'd4},
        '{2'd1, 16'd16,  6'd16, 4'd1, 6'd16},
        '{2'd1, 16'd40,  6'd16, 4'd3, 6'd8},
        '{2'd2, 16'd100, 6'd32, 4'd4, 6'd4},
        '{2'd3, 16'd5,   6'd5,  4'd1, 6'd5},
        '{2'd0, 16'd1,   6'd1,  4'd1, 6'd1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input int ch, input int sel, input int bsz, input int cnt, input bit ien);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_sel = 6'(sel);
        cfg_bsize = 2'(bsz); cfg_count = 16'(cnt); cfg_ien = ien;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Wait at negedges for a command; got=0 if none within max cycles.
    task automatic wait_cmd(input int max, output bit got);
        got = 1'b0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (cmd_valid) begin got = 1'b1; break; end
        end
    endtask

    // Accept the visible command, then pulse done after a short gap.
    task automatic finish_cmd();
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (2) @(negedge clk);
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
    endtask

    task automatic serve(output bit got, output int ch, output int bytes);
        wait_cmd(8, got);
        ch = int'(cmd_ch);
        bytes = int'(cmd_bytes);
        if (got) finish_cmd();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit got;
        int ch, by;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!cmd_valid && !irq, "R1 valid/irq", int'(cmd_valid), 0);
        check(ch_done == 0 && ch_active == 0, "R1 flags", int'(ch_done | ch_active), 0);

        // R5: table of burst-size codes and counts
        preq[0] = 1'b1;
        foreach (VECS[v]) begin
            int nb;
            nb = 0;
            load(0, 0, VECS[v].bsz, VECS[v].cnt, 1'b0);
            for (int b = 0; b < 8; b++) begin
                serve(got, ch, by);
                if (!got) break;
                nb++;
                if (nb == 1) check(by == VECS[v].first, "R5 first burst", by, VECS[v].first);
                if (nb == VECS[v].nb) check(by == VECS[v].last, "R5 last burst", by, VECS[v].last);
            end
            check(nb == VECS[v].nb, "R5 burst count", nb, VECS[v].nb);
        end
        preq[0] = 1'b0;

        // R2: active channel without request, and zero-count load
        load(1, 1, 0, 8, 1'b0);
        load(5, 1, 0, 0, 1'b0);
        check(ch_active[5] == 1'b0, "R2 zero count inactive", int'(ch_active[5]), 0);
        wait_cmd(6, got);
        check(!got, "R2 no request no command", int'(got), 0);

        // R3: group 0 beats group 2
        load(9, 2, 0, 8, 1'b0);
        preq[1] = 1'b1; preq[2] = 1'b1;
        serve(got, ch, by);
        check(got && ch == 1, "R3 higher group first", ch, 1);
        serve(got, ch, by);
        check(got && ch == 9, "R3 lower group next", ch, 9);
        preq[1] = 1'b0; preq[2] = 1'b0;

        // R4: rotation within group 1
        load(4, 3, 0, 16, 1'b0);
        load(5, 3, 0, 16, 1'b0);
        load(6, 3, 0, 16, 1'b0);
        preq[3] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            int exp;
            exp = 4 + (i % 3);
            serve(got, ch, by);
            if (i < 4) check(got && ch == exp, "R4 rotation order", ch, exp);
        end
        preq[3] = 1'b0;

        // R6 and R11: stall a command, then a higher-priority request arrives mid-burst
        load(10, 4, 2, 32, 1'b0);
        load(2, 5, 0, 8, 1'b0);
        preq[4] = 1'b1;
        wait_cmd(8, got);
        ch = int'(cmd_ch); by = int'(cmd_bytes);
        repeat (3) @(negedge clk);
        check(cmd_valid && int'(cmd_ch) == ch && int'(cmd_bytes) == by, "R6 held while stalled",
              int'(cmd_bytes), by);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        preq[5] = 1'b1;
        preq[4] = 1'b0;
        repeat (4) @(negedge clk);
        check(!cmd_valid, "R7 no command while outstanding", int'(cmd_valid), 0);
        check(ch_active[10] == 1'b1, "R11 burst not cut", int'(ch_active[10]), 1);
        mv_done = 1'b1;
        @(negedge clk);
        mv_done = 1'b0;
        check(ch_done[10] == 1'b1, "R11 burst ran to its end", int'(ch_done[10]), 1);
        serve(got, ch, by);
        check(got && ch == 2, "R11 higher priority next", ch, 2);
        preq[5] = 1'b0;

        // R8: external edge versus held level
        load(12, 38, 0, 64, 1'b0);
        xreq[0] = 1'b1;
        serve(got, ch, by);
        check(got && ch == 12, "R8 edge makes a request", ch, 12);
        wait_cmd(10, got);
        check(!got, "R8 held level no second burst", int'(got), 0);
        xreq[0] = 1'b0;
        repeat (4) @(negedge clk);
        xreq[0] = 1'b1;
        serve(got, ch, by);
        check(got && ch == 12, "R8 new edge served", ch, 12);
        xreq[0] = 1'b0;
        load(12, 38, 0, 0, 1'b0);

        // R9: interrupt masking and completion flags
        check(!irq, "R9 no irq from masked channels", int'(irq), 0);
        load(7, 6, 1, 16, 1'b1);
        preq[6] = 1'b1;
        serve(got, ch, by);
        preq[6] = 1'b0;
        @(negedge clk);
        check(ch_done[7] && !ch_active[7], "R9 done set active clear",
              int'({ch_done[7], ch_active[7]}), 2);
        check(irq == 1'b1, "R9 irq raised", int'(irq), 1);

        // R10: reload clears done and irq
        load(7, 6, 1, 8, 1'b1);
        check(!ch_done[7] && ch_active[7], "R10 reload clears done",
              int'({ch_done[7], ch_active[7]}), 1);
        check(irq == 1'b0, "R10 irq drops", int'(irq), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule